// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit

This block moves a data word left or right by a variable number of bit positions in one pass. A 3-bit operation code selects one of six operations: logical shifts, arithmetic shifts and rotations, each in both directions. Two further codes pass the word through unchanged. The arithmetic shifts replicate an end bit of the original word into the vacated positions, and they do so in both directions. A right arithmetic shift copies the most significant bit. A left arithmetic shift copies the least significant bit.

The datapath is a chain of log2(WIDTH) stages. Each stage is steered by one bit of the amount and moves the word by a power of two. For shifts, an amount of WIDTH or more saturates to a word made entirely of the fill bit. For rotations, only the amount modulo WIDTH is used. A parameter places an optional result register at the output. That register adds one cycle of latency and clears synchronously. WIDTH must be a power of two.

Top module: `shift_rotate_unit`

## Requirements
- R1: Op code 000 shifts the operand left by the amount, and the vacated low bits are zero.
- R2: Op code 001 shifts the operand right by the amount, and the vacated high bits are zero.
- R3: Op code 011 shifts right by the amount, and every vacated high bit equals bit WIDTH-1 of the original operand.
- R4: Op code 010 shifts left by the amount, and every vacated low bit equals bit 0 of the original operand.
- R5: Op codes 100 (left) and 101 (right) rotate the operand, so bits leaving one end re-enter at the other. The amount is used modulo WIDTH.
- R6: Op codes 110 and 111 return the operand unchanged, whatever the amount.
- R7: An amount of zero returns the operand unchanged for every op code.
- R8: For op codes 000 to 011, an amount of WIDTH or more gives a result with every bit equal to the fill bit. The fill bit is 0 for logical shifts, the original LSB for code 010 and the original MSB for code 011.
- R9: With REGISTER_OUT=1, the result appears exactly one clock edge after the inputs are sampled. A high rst at a clock edge clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| operand | input | WIDTH | Word to shift or rotate |
| amount | input | AMT_W | Number of positions, default width log2(WIDTH)+1 |
| op | input | 3 | Operation code |
| result | output | WIDTH | Shifted, rotated or passed word |

## Verification
The two functions that can meet in one input are saturation and end-bit replication. An arithmetic shift by WIDTH or more must fill the whole word with the replicated bit, not with zeros. The bench drives arithmetic left and right shifts with amounts from WIDTH up to the largest encodable value, on operands whose relevant end bit is 1. Each result is compared against an all-ones word and against a bit-by-bit reference model. Rotations by the same large amounts are checked to confirm that they wrap modulo WIDTH instead of saturating.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

    typedef enum logic [2:0] {
        OP_SHL_LOG = 3'b000,
        OP_SHR_LOG = 3'b001,
        OP_SHL_ARI = 3'b010,
        OP_SHR_ARI = 3'b011,
        OP_ROT_L   = 3'b100,
        OP_ROT_R   = 3'b101,
        OP_THRU_A  = 3'b110,
        OP_THRU_B  = 3'b111
    } sr_op_e;

    typedef struct packed {
        logic go_right;
        logic rotate;
        logic arith;
        logic bypass;
    } sr_ctrl_t;

    function automatic sr_ctrl_t decode_op(sr_op_e op);
        sr_ctrl_t c;
        c.bypass   = (op == OP_THRU_A) || (op == OP_THRU_B);
        c.rotate   = (op == OP_ROT_L) || (op == OP_ROT_R);
        c.arith    = (op == OP_SHL_ARI) || (op == OP_SHR_ARI);
        c.go_right = (op == OP_SHR_LOG) || (op == OP_SHR_ARI) || (op == OP_ROT_R);
        return c;
    endfunction

endpackage

// File: rtl/sr_decode.sv
module sr_decode
    import shift_rotate_pkg::*;
(
    input  sr_op_e   op,
    input  logic     lsb,
    input  logic     msb,
    output sr_ctrl_t ctrl,
    output logic     fill
);
    always_comb begin
        ctrl = decode_op(op);
        // Arithmetic shifts replicate the end bit that the shift moves away from
        if (ctrl.arith) fill = ctrl.go_right ? msb : lsb;
        else            fill = 1'b0;
    end
endmodule

// File: rtl/sr_barrel_stage.sv
module sr_barrel_stage
    import shift_rotate_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
)(
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    input  sr_ctrl_t         ctrl,
    input  logic             fill,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] left_v;
    logic [WIDTH-1:0] right_v;
    logic [DIST-1:0]  low_in;
    logic [DIST-1:0]  high_in;

    always_comb begin
        low_in  = ctrl.rotate ? din[WIDTH-1 -: DIST] : {DIST{fill}};
        high_in = ctrl.rotate ? din[DIST-1:0]        : {DIST{fill}};
        left_v  = {din[WIDTH-1-DIST:0], low_in};
        right_v = {high_in, din[WIDTH-1:DIST]};
        if (!en)               dout = din;
        else if (ctrl.go_right) dout = right_v;
        else                   dout = left_v;
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import shift_rotate_pkg::*;
#(
    parameter int WIDTH        = 16,
    parameter int AMT_W        = $clog2(WIDTH) + 1,
    parameter bit REGISTER_OUT = 1'b1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] operand,
    input  logic [AMT_W-1:0] amount,
    input  logic [2:0]       op,
    output logic [WIDTH-1:0] result
);
    localparam int LOG2 = $clog2(WIDTH);

    sr_op_e   op_e;
    sr_ctrl_t ctrl;
    logic     fill;
    logic     over;
    logic [LOG2:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0] core;

    assign op_e = sr_op_e'(op);

    sr_decode u_dec (
        .op   (op_e),
        .lsb  (operand[0]),
        .msb  (operand[WIDTH-1]),
        .ctrl (ctrl),
        .fill (fill)
    );

    assign chain[0] = operand;

    for (genvar k = 0; k < LOG2; k++) begin : g_stage
        sr_barrel_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
            .din  (chain[k]),
            .en   (amount[k]),
            .ctrl (ctrl),
            .fill (fill),
            .dout (chain[k+1])
        );
    end

    // Shifts saturate at WIDTH; rotations ignore the upper amount bits
    assign over = 32'(amount) >= 32'(WIDTH);

    always_comb begin
        if (ctrl.bypass)                core = operand;
        else if (!ctrl.rotate && over)  core = {WIDTH{fill}};
        else                            core = chain[LOG2];
    end

    if (REGISTER_OUT) begin : g_reg
        logic [WIDTH-1:0] result_q;
        always_ff @(posedge clk) begin
            if (rst) result_q <= '0;
            else     result_q <= core;
        end
        assign result = result_q;

        a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> result == '0);
    end else begin : g_comb
        assign result = core;
    end

    a_r7_zero_amount: assert property (@(posedge clk) disable iff (rst)
        amount == '0 |-> core == operand);
    a_r6_pass_codes: assert property (@(posedge clk) disable iff (rst)
        op[2:1] == 2'b11 |-> core == operand);
    a_r8_logic_saturate: assert property (@(posedge clk) disable iff (rst)
        (op[2:1] == 2'b00 && 32'(amount) >= 32'(WIDTH)) |-> core == '0);
    a_r5_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
        (op[2:1] == 2'b10) |-> $countones(core) == $countones(operand));
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b011) |-> core[WIDTH-1] == operand[WIDTH-1]);
    a_r4_lsb_kept: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b010) |-> core[0] == operand[0]);

endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
    localparam int W = 16;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  operand = '0;
    logic [AW-1:0] amount = '0;
    logic [2:0]    op = '0;
    logic [W-1:0]  result;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    shift_rotate_unit #(.WIDTH(W), .AMT_W(AW), .REGISTER_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .operand(operand), .amount(amount), .op(op), .result(result)
    );

    typedef struct packed {
        logic [3:0]    req;
        logic [2:0]    op;
        logic [AW-1:0] amt;
        logic [W-1:0]  a;
        logic [W-1:0]  exp;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 3'b000, 5'd4,  16'h8421, 16'h4210},  // R1
        '{4'd2, 3'b001, 5'd4,  16'h8421, 16'h0842},  // R2
        '{4'd4, 3'b010, 5'd3,  16'h0F01, 16'h780F},  // R4 lsb 1 replicated
        '{4'd4, 3'b010, 5'd3,  16'h0F02, 16'h7810},  // R4 lsb 0
        '{4'd3, 3'b011, 5'd4,  16'h8421, 16'hF842},  // R3 sign 1
        '{4'd3, 3'b011, 5'd4,  16'h4210, 16'h0421},  // R3 sign 0
        '{4'd5, 3'b100, 5'd4,  16'h8421, 16'h4218},  // R5 left
        '{4'd5, 3'b101, 5'd4,  16'h8421, 16'h1842},  // R5 right
        '{4'd5, 3'b100, 5'd20, 16'h8421, 16'h4218},  // R5 modulo
        '{4'd5, 3'b101, 5'd16, 16'h1234, 16'h1234},  // R5 full turn
        '{4'd6, 3'b110, 5'd7,  16'hBEEF, 16'hBEEF},  // R6
        '{4'd6, 3'b111, 5'd3,  16'h1234, 16'h1234},  // R6
        '{4'd7, 3'b000, 5'd0,  16'hA5A5, 16'hA5A5},  // R7
        '{4'd8, 3'b000, 5'd16, 16'hFFFF, 16'h0000},  // R8 logical
        '{4'd8, 3'b001, 5'd16, 16'h8000, 16'h0000},  // R8 logical
        '{4'd8, 3'b011, 5'd31, 16'h8000, 16'hFFFF},  // R8 arithmetic right
        '{4'd8, 3'b010, 5'd17, 16'h0001, 16'hFFFF}   // R8 arithmetic left
    };

    function automatic logic [W-1:0] ref_model(logic [2:0] o, int n, logic [W-1:0] a);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            case (o)
                3'b000: r[i] = (i - n >= 0) ? a[i-n] : 1'b0;
                3'b001: r[i] = (i + n < W)  ? a[i+n] : 1'b0;
                3'b010: r[i] = (i - n >= 0) ? a[i-n] : a[0];
                3'b011: r[i] = (i + n < W)  ? a[i+n] : a[W-1];
                3'b100: r[i] = a[(i - (n % W) + W) % W];
                3'b101: r[i] = a[(i + n) % W];
                default: r[i] = a[i];
            endcase
        end
        return r;
    endfunction

    function automatic string req_of(logic [2:0] o, int n);
        if (n == 0) return "R7";
        case (o)
            3'b000: return (n >= W) ? "R8" : "R1";
            3'b001: return (n >= W) ? "R8" : "R2";
            3'b010: return (n >= W) ? "R8" : "R4";
            3'b011: return (n >= W) ? "R8" : "R3";
            3'b100, 3'b101: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, sample at the next falling edge
    task automatic apply(logic [2:0] o, logic [AW-1:0] n, logic [W-1:0] a);
        @(negedge clk);
        op = o; amount = n; operand = a;
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] ops [4];
        ops[0] = 16'h8421; ops[1] = 16'h7FFE; ops[2] = 16'h0001; ops[3] = 16'hC3A5;

        // R9: reset state with nonzero inputs present
        operand = 16'hFFFF; op = 3'b110; amount = '0;
        repeat (3) @(negedge clk);
        check("R9 reset value", result, '0);
        rst = 1'b0;

        // Table of directed vectors
        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].op, VECS[v].amt, VECS[v].a);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), result, VECS[v].exp);
        end

        // Every op, every amount, several operands against the reference model
        for (int o = 0; o < 8; o++) begin
            for (int n = 0; n < (1 << AW); n++) begin
                for (int k = 0; k < 4; k++) begin
                    apply(3'(o), AW'(n), ops[k]);
                    check($sformatf("%s op=%0d amt=%0d a=%h", req_of(3'(o), n), o, n, ops[k]),
                          result, ref_model(3'(o), n, ops[k]));
                end
            end
        end

        // R9: latency, the output keeps the old value until the next rising edge
        apply(3'b110, '0, 16'h1357);
        @(negedge clk);
        op = 3'b110; operand = 16'h2468;
        #1;
        check("R9 before edge", result, 16'h1357);
        @(negedge clk);
        check("R9 after one edge", result, 16'h2468);

        // R9: reset applied mid-run clears the register
        @(negedge clk);
        rst = 1'b1; op = 3'b110; operand = 16'hAAAA;
        @(negedge clk);
        check("R9 mid-run reset", result, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 resume after reset", result, 16'hAAAA);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule